// File: doc/BRIEF.md
# Five-Level Stacked-Carrier PWM Modulator

This block turns a signed reference sample into gate commands for one leg of a five-level hybrid H-bridge inverter. The leg has four bridge switches and one auxiliary switch that ties the load to the centre tap of the DC supply. Four triangular carriers sit in adjacent amplitude bands that together cover the full reference range. The block counts how many carriers lie strictly below the reference and subtracts two, which gives an output level from -2 to +2. It then encodes that level into the five switch enables and registers them.

All four carriers come from one phase counter, which is driven by a two-state machine. In `PH_RISE` the index counts up. On reaching the peak it moves to `PH_FALL` (transition "peak turn"), and in `PH_FALL` it counts down. On reaching the floor it returns to `PH_RISE` (transition "floor turn"). The floor turn is the carrier period boundary, and it is the only point at which a new carrier arrangement is taken in. Three arrangements are available:
- All carriers in phase.
- The two lower carriers mirrored against the two upper ones.
- The two inner carriers running at twice the rate of the outer ones.

The registered level is held as a named code: `LV_NEG2`, `LV_NEG1`, `LV_ZERO`, `LV_POS1`, `LV_POS2`.

Top module: `mlpwm_top`

## Requirements
- R1: There are four carriers. Carrier k (k = 0..3) equals -2048 + 1024*k + t, where t = idx*16. The index idx rises 0..63 and then falls 63..0, and each extreme is held for two consecutive cycles, so one carrier period is 128 cycles.
- R2: The level equals the number of carriers strictly below the reference, minus 2. It is coded as 3-bit two's complement on `level_out`. Reference values -2048, -1024, 0, 1024 and 2047 give a constant -2, -1, 0, +1 and +2 in every mode.
- R3: Mode code 00 (in phase): all carriers use t. With the reference at 512, the level is +1 in exactly 64 of any 128 consecutive cycles, and it changes exactly 2 times per 128 cycles.
- R4: Mode code 01 (mirrored): carriers 0 and 1 use (63-idx)*16, and carriers 2 and 3 use t. With the reference at -512, the level is -1 in 64 of 128 cycles.
- R5: Mode code 10 (double-rate inner): carriers 1 and 2 use 16*(idx<32 ? 2*idx : 2*(63-idx)+1), and carriers 0 and 3 use t. With the reference at 512, the level changes 4 times per 128 cycles.
- R6: `mode_sel` is taken in only in the cycle in which the counter is falling at idx 0. A request withdrawn before that cycle has no effect. Code 11 behaves as code 00.
- R7: The switch outputs {`sw_aux`, `sw_bridge[3:0]`} follow a fixed table. Level +2 gives 0,1100. Level +1 gives 1,0000. Level 0 gives 0,0001. Level -1 gives 1,0100. Level -2 gives 0,0011. No other pattern appears.
- R8: Outputs are registered. After a rising edge they reflect the reference and carrier state that were present before that edge.
- R9: A synchronous reset forces level 0 and the switches to 0,0001. It also restarts the counter rising from idx 0 with the in-phase arrangement.
- R10: A sinusoidal reference that moves by less than 16 LSB per cycle never makes the level step by more than one between consecutive cycles, for modulation indices 0.6 to 1.0 in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Requested carrier arrangement (00 in phase, 01 mirrored, 10 double-rate inner, 11 as 00) |
| ref_sample | input | 12 | Signed reference sample |
| level_out | output | 3 | Registered output level, two's complement -2..+2 |
| sw_aux | output | 1 | Auxiliary centre-tap switch enable |
| sw_bridge | output | 4 | Bridge switch enables, bit 3 = first switch .. bit 0 = fourth switch |

## Verification
The hardest situation to reach from the ports is a mode request that changes in the middle of a carrier period. That includes a request raised and dropped again before the floor turn, which must leave the arrangement untouched. The ports do not expose the counter phase. The stimulus therefore starts each scenario from reset, so that the phase is known. It holds the reference at a value that looks different under the old and the new arrangement. Each output cycle is then compared with an independent model of the counter and carriers, built from the requirement formulas, so any early or late latch shows up as a level mismatch.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

    localparam int NUM_LEVELS = 5;
    localparam int NUM_CAR    = NUM_LEVELS - 1;
    localparam int CNT_W      = $clog2(NUM_CAR + 1);

    typedef enum logic [1:0] {
        CAR_PD  = 2'b00,
        CAR_POD = 2'b01,
        CAR_VF  = 2'b10,
        CAR_RSV = 2'b11
    } car_mode_e;

    typedef enum logic {
        PH_RISE = 1'b0,
        PH_FALL = 1'b1
    } ph_state_e;

    typedef enum logic [2:0] {
        LV_NEG2 = 3'b110,
        LV_NEG1 = 3'b111,
        LV_ZERO = 3'b000,
        LV_POS1 = 3'b001,
        LV_POS2 = 3'b010
    } level_e;

    typedef struct packed {
        logic       aux;
        logic [3:0] bridge;
    } sw_state_t;

endpackage

// File: rtl/mlpwm_carrier_gen.sv
module mlpwm_carrier_gen
    import mlpwm_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int HALF_STEPS = 64
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [1:0]                     mode_req,
    output logic [NUM_CAR-1:0][DATA_W-1:0] car_o
);

    localparam int BAND     = 2 ** (DATA_W - 2);
    localparam int SCALE    = BAND / HALF_STEPS;
    localparam int IDX_W    = $clog2(HALF_STEPS);
    localparam int IDX_TOP  = HALF_STEPS - 1;
    localparam int IDX_MID  = HALF_STEPS / 2;

    ph_state_e          st_q, st_d;
    car_mode_e          mode_q, mode_d;
    logic [IDX_W-1:0]   idx_q, idx_d;
    logic               at_peak, at_floor;

    logic [IDX_W-1:0]   idx_mirror, idx_fast;
    logic [DATA_W-1:0]  tri_slow, tri_mirror, tri_fast;

    assign at_peak  = (idx_q == IDX_W'(IDX_TOP));
    assign at_floor = (idx_q == '0);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PH_RISE;
            idx_q  <= '0;
            mode_q <= CAR_PD;
        end else begin
            st_q   <= st_d;
            idx_q  <= idx_d;
            mode_q <= mode_d;
        end
    end

    // next state: peak turn and floor turn
    always_comb begin
        st_d   = st_q;
        idx_d  = idx_q;
        mode_d = mode_q;
        unique case (st_q)
            PH_RISE: begin
                if (at_peak) st_d  = PH_FALL;
                else         idx_d = idx_q + 1'b1;
            end
            PH_FALL: begin
                if (at_floor) begin
                    st_d   = PH_RISE;
                    mode_d = car_mode_e'(mode_req);
                end else begin
                    idx_d  = idx_q - 1'b1;
                end
            end
            default: st_d = PH_RISE;
        endcase
    end

    // triangle shapes derived from the one index
    always_comb begin
        idx_mirror = IDX_W'(IDX_TOP) - idx_q;
        if (idx_q < IDX_W'(IDX_MID)) idx_fast = {idx_q[IDX_W-2:0], 1'b0};
        else                         idx_fast = {idx_mirror[IDX_W-2:0], 1'b1};
        tri_slow   = DATA_W'(idx_q)      * DATA_W'(SCALE);
        tri_mirror = DATA_W'(idx_mirror) * DATA_W'(SCALE);
        tri_fast   = DATA_W'(idx_fast)   * DATA_W'(SCALE);
    end

    // per-carrier band offset and shape selection
    for (genvar k = 0; k < NUM_CAR; k++) begin : g_car
        localparam logic [DATA_W-1:0] BASE  = DATA_W'(k * BAND - 2 ** (DATA_W - 1));
        localparam bit                LOWER = (k < NUM_CAR / 2);
        localparam bit                INNER = (k > 0) && (k < NUM_CAR - 1);
        logic [DATA_W-1:0] shape;
        always_comb begin
            unique case (mode_q)
                CAR_POD: shape = LOWER ? tri_mirror : tri_slow;
                CAR_VF:  shape = INNER ? tri_fast   : tri_slow;
                default: shape = tri_slow;
            endcase
            car_o[k] = BASE + shape;
        end
    end

    AST_TURN_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_FALL && at_floor) |=> (st_q == PH_RISE && idx_q == '0)); // R1
    AST_TURN_PEAK: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_RISE && at_peak) |=> (st_q == PH_FALL && idx_q == IDX_W'(IDX_TOP))); // R1
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(st_q == PH_FALL && at_floor) |=> $stable(mode_q)); // R6

endmodule

// File: rtl/mlpwm_level_cmp.sv
module mlpwm_level_cmp
    import mlpwm_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [DATA_W-1:0]              ref_i,
    input  logic [NUM_CAR-1:0][DATA_W-1:0] car_i,
    output logic [CNT_W-1:0]               cnt_o
);

    logic [NUM_CAR-1:0] above;

    for (genvar k = 0; k < NUM_CAR; k++) begin : g_cmp
        assign above[k] = ($signed(ref_i) > $signed(car_i[k]));
    end

    assign cnt_o = CNT_W'($countones(above));

    AST_THERMO: assert property (@(posedge clk) disable iff (rst)
        (((above + 1'b1) & above) == '0)); // R2

endmodule

// File: rtl/mlpwm_sw_encoder.sv
module mlpwm_sw_encoder
    import mlpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [2:0]       level_o,
    output logic             aux_o,
    output logic [3:0]       bridge_o
);

    level_e    level_q, level_d;
    sw_state_t sw_q, sw_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= LV_ZERO;
            sw_q    <= '{aux: 1'b0, bridge: 4'b0001};
        end else begin
            level_q <= level_d;
            sw_q    <= sw_d;
        end
    end

    always_comb begin
        unique case (cnt_i)
            CNT_W'(0): level_d = LV_NEG2;
            CNT_W'(1): level_d = LV_NEG1;
            CNT_W'(2): level_d = LV_ZERO;
            CNT_W'(3): level_d = LV_POS1;
            CNT_W'(4): level_d = LV_POS2;
            default:   level_d = LV_ZERO;
        endcase
    end

    always_comb begin
        unique case (level_d)
            LV_POS2: sw_d = '{aux: 1'b0, bridge: 4'b1100};
            LV_POS1: sw_d = '{aux: 1'b1, bridge: 4'b0000};
            LV_ZERO: sw_d = '{aux: 1'b0, bridge: 4'b0001};
            LV_NEG1: sw_d = '{aux: 1'b1, bridge: 4'b0100};
            LV_NEG2: sw_d = '{aux: 1'b0, bridge: 4'b0011};
            default: sw_d = '{aux: 1'b0, bridge: 4'b0001};
        endcase
    end

    assign level_o  = level_q;
    assign aux_o    = sw_q.aux;
    assign bridge_o = sw_q.bridge;

    AST_LEGAL_SW: assert property (@(posedge clk) disable iff (rst)
        (sw_q == 5'b01100 || sw_q == 5'b10000 || sw_q == 5'b00001 ||
         sw_q == 5'b10100 || sw_q == 5'b00011)); // R7
    AST_AUX_ODD: assert property (@(posedge clk) disable iff (rst)
        (sw_q.aux == level_q[0])); // R7
    AST_RESET_ZERO: assert property (@(posedge clk)
        $past(rst) |-> (level_q == LV_ZERO && sw_q == 5'b00001)); // R9

endmodule

// File: rtl/mlpwm_top.sv
module mlpwm_top
    import mlpwm_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int HALF_STEPS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic [DATA_W-1:0] ref_sample,
    output logic [2:0]        level_out,
    output logic              sw_aux,
    output logic [3:0]        sw_bridge
);

    logic [NUM_CAR-1:0][DATA_W-1:0] carriers;
    logic [CNT_W-1:0]               n_below;

    mlpwm_carrier_gen #(
        .DATA_W     (DATA_W),
        .HALF_STEPS (HALF_STEPS)
    ) u_car (
        .clk      (clk),
        .rst      (rst),
        .mode_req (mode_sel),
        .car_o    (carriers)
    );

    mlpwm_level_cmp #(
        .DATA_W (DATA_W)
    ) u_cmp (
        .clk   (clk),
        .rst   (rst),
        .ref_i (ref_sample),
        .car_i (carriers),
        .cnt_o (n_below)
    );

    mlpwm_sw_encoder u_enc (
        .clk      (clk),
        .rst      (rst),
        .cnt_i    (n_below),
        .level_o  (level_out),
        .aux_o    (sw_aux),
        .bridge_o (sw_bridge)
    );

endmodule

// File: tb/mlpwm_top_tb.sv
module mlpwm_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 64;
    localparam int SCALE      = 16;
    localparam int PERIOD     = 2 * HALF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'b00;
    logic [11:0] ref_sample = '0;
    logic [2:0]  level_out;
    logic        sw_aux;
    logic [3:0]  sw_bridge;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // independent model state
    int m_idx = 0;
    bit m_up = 1;
    int m_mode = 0;
    int exp_lvl = 0;
    bit have_exp = 0;
    int mism = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mlpwm_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .mode_sel   (mode_sel),
        .ref_sample (ref_sample),
        .level_out  (level_out),
        .sw_aux     (sw_aux),
        .sw_bridge  (sw_bridge)
    );

    function automatic int exp_count(int r, int idx, int md);
        int cnt = 0;
        for (int k = 0; k < 4; k++) begin
            int base = k * 1024 - 2048;
            int slow = idx * SCALE;
            int mirr = (HALF - 1 - idx) * SCALE;
            int fast = ((idx < HALF / 2) ? 2 * idx : 2 * (HALF - 1 - idx) + 1) * SCALE;
            int sel  = slow;
            if (md == 1 && k < 2) sel = mirr;
            if (md == 2 && (k == 1 || k == 2)) sel = fast;
            if (r > base + sel) cnt++;
        end
        return cnt;
    endfunction

    function automatic logic [4:0] pat(int lv);
        case (lv)
            2:       return 5'b01100;
            1:       return 5'b10000;
            0:       return 5'b00001;
            -1:      return 5'b10100;
            default: return 5'b00011;
        endcase
    endfunction

    function automatic int cur_lvl();
        return int'($signed(level_out));
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(int r, bit do_rst);
        if (have_exp) begin
            if (cur_lvl() != exp_lvl || {sw_aux, sw_bridge} != pat(exp_lvl)) begin
                mism++;
                if (mism < 4)
                    $display("  model mismatch at %0t: level %0d model %0d", $time, cur_lvl(), exp_lvl);
            end
        end
        ref_sample = 12'(r);
        rst = do_rst;
        if (do_rst) begin
            exp_lvl = 0; m_idx = 0; m_up = 1; m_mode = 0;
        end else begin
            exp_lvl = exp_count(r, m_idx, m_mode) - 2;
            if (m_up) begin
                if (m_idx == HALF - 1) m_up = 0;
                else m_idx++;
            end else begin
                if (m_idx == 0) begin
                    m_up = 1;
                    m_mode = (mode_sel == 2'b11) ? 0 : int'(mode_sel);
                end else m_idx--;
            end
        end
        have_exp = 1;
        @(negedge clk);
    endtask

    task automatic run(int r, int n);
        for (int i = 0; i < n; i++) step(r, 1'b0);
    endtask

    task automatic restart(int md);
        mode_sel = 2'(md);
        step(0, 1'b1);
        run(0, PERIOD + 2);
    endtask

    task automatic t_reset();
        step(0, 1'b1);
        step(0, 1'b1);
        step(0, 1'b1);
        check(cur_lvl() == 0, "R9", "reset level", cur_lvl(), 0);
        check({sw_aux, sw_bridge} == 5'b00001, "R9", "reset switches", int'({sw_aux, sw_bridge}), 1);
    endtask

    task automatic t_fixed();
        int refs [5] = '{-2048, -1024, 0, 1024, 2047};
        for (int md = 0; md < 4; md++) begin
            restart(md);
            for (int j = 0; j < 5; j++) begin
                int bad = 0;
                for (int i = 0; i < PERIOD; i++) begin
                    step(refs[j], 1'b0);
                    if (cur_lvl() != j - 2) bad++;
                end
                check(bad == 0, "R2", "constant level cycles off", bad, 0);
            end
        end
    endtask

    task automatic t_latency();
        restart(0);
        step(0, 1'b0);
        check(cur_lvl() == 0, "R8", "level before step", cur_lvl(), 0);
        step(2047, 1'b0);
        check(cur_lvl() == 2, "R8", "level one edge after step", cur_lvl(), 2);
        check({sw_aux, sw_bridge} == 5'b01100, "R7", "pattern at +2", int'({sw_aux, sw_bridge}), 12);
        step(-1024, 1'b0);
        check({sw_aux, sw_bridge} == 5'b10100, "R7", "pattern at -1", int'({sw_aux, sw_bridge}), 20);
        step(2047, 1'b1);
        check(cur_lvl() == 0, "R9", "mid-run reset level", cur_lvl(), 0);
    endtask

    task automatic duty(int md, int r, int lv, int exp_on, int exp_tr, string req);
        int on = 0;
        int tr = 0;
        int prev;
        restart(md);
        mism = 0;
        step(r, 1'b0);
        prev = cur_lvl();
        for (int i = 0; i < PERIOD; i++) begin
            step(r, 1'b0);
            if (cur_lvl() == lv) on++;
            if (cur_lvl() != prev) tr++;
            prev = cur_lvl();
        end
        check(on == exp_on, req, "cycles at level", on, exp_on);
        check(tr == exp_tr, req, "level changes per period", tr, exp_tr);
        check(mism == 0, req, "model mismatches", mism, 0);
    endtask

    task automatic t_mode_latch();
        restart(0);
        mism = 0;
        mode_sel = 2'b01;
        run(-512, 40);
        mode_sel = 2'b00;
        run(-512, 2 * PERIOD);
        check(mism == 0, "R6", "withdrawn request mismatches", mism, 0);
        mism = 0;
        mode_sel = 2'b01;
        run(-512, 3 * PERIOD);
        check(mism == 0, "R6", "held request mismatches", mism, 0);
        mism = 0;
        mode_sel = 2'b11;
        run(512, 3 * PERIOD);
        check(mism == 0, "R6", "reserved code mismatches", mism, 0);
    endtask

    task automatic t_sweep(int md);
        int jumps = 0;
        int illegal = 0;
        int prev;
        restart(md);
        mism = 0;
        prev = cur_lvl();
        for (int mi = 6; mi <= 10; mi++) begin
            for (int n = 0; n < 1280; n++) begin
                int r = $rtoi(real'(mi) / 10.0 * 2047.0 * $sin(2.0 * 3.14159265358979 * real'(n) / 1280.0));
                logic [4:0] p;
                step(r, 1'b0);
                p = {sw_aux, sw_bridge};
                if (!(p == 5'b01100 || p == 5'b10000 || p == 5'b00001 || p == 5'b10100 || p == 5'b00011))
                    illegal++;
                if (cur_lvl() - prev > 1 || prev - cur_lvl() > 1) jumps++;
                prev = cur_lvl();
            end
        end
        check(jumps == 0, "R10", "level jumps above one", jumps, 0);
        check(illegal == 0, "R7", "illegal switch patterns", illegal, 0);
        check(mism == 0, "R10", "sweep model mismatches", mism, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_fixed();
        t_latency();
        duty(0, 512, 1, 64, 2, "R3");
        duty(1, -512, -1, 64, 2, "R4");
        duty(2, 512, 1, 64, 4, "R5");
        mism = 0;
        restart(0);
        run(300, PERIOD);
        check(mism == 0, "R1", "carrier shape mismatches", mism, 0);
        t_mode_latch();
        for (int md = 0; md < 3; md++) t_sweep(md);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule